// File: doc/BRIEF.md
# Clock Output Enable Bank

This block keeps the per-output enable settings of a clock distribution device and applies them to eight clock outputs. An 8-bit enable register decides which outputs run. A set bit lets the output follow its source clock. A clear bit holds the output low. Each output is gated inside its own clock domain, so switching it on or off never produces a shortened pulse or a spike.

A second, read-only byte reports the levels of three strap pins. These are captured on the first register clock after reset and returned inverted. The remaining bits of that byte are reserved and read as ones. Software reaches both bytes through a plain byte port with an address, write data, a write strobe and combinational read data. The serial bus slave that would drive this port sits outside the block.

Top module: `clk_oe_bank`

## Requirements
- R1: After reset the enable register at address 5 reads 0xFF, and every output follows its source clock.
- R2: A write strobe with address 5 stores the write data in the enable register on that clock edge, and a later read at address 5 returns it.
- R3: Enable bit i gates output i. The bit order is: bit 7 SDRAM clock 3, bit 6 SDRAM clock 2, bit 5 SDRAM clock 1, bit 4 SDRAM clock 0, bit 3 48 MHz, bit 2 24 MHz, bit 1 reference 1, bit 0 reference 0.
- R4: An output whose enable bit is 0 stays low and does not switch.
- R5: An output whose enable bit is 1 equals its source clock at every sample, once its synchronizer has settled.
- R6: An output changes only at the same moment as its source clock and in the same direction, and it is never high while its source is low, even while its enable bit is changing.
- R7: Address 4 reads bit 5 = inverted select strap, bit 3 = inverted FS1 strap, bit 1 = inverted FS3 strap, and 1 in bits 7, 6, 4, 2 and 0. The strap values are captured on the first clock after reset, and later pin changes do not alter them.
- R8: Writes to address 4 have no effect on what address 4 reads.
- R9: Writes to any address other than 5 leave the enable register unchanged, and reads of any address other than 4 or 5 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| addr | input | 3 | Byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed byte |
| strapSel | input | 1 | 24/48 select strap pin |
| strapFs1 | input | 1 | Frequency-select strap pin FS1 |
| strapFs3 | input | 1 | Frequency-select strap pin FS3 |
| srcClk | input | 8 | Source clocks, one per output |
| clkOut | output | 8 | Gated clock outputs |

## Verification
The hardest case to reach from the ports is an enable change that arrives while a source clock is high. A wrong gate would cut that pulse or add a spike there. The bench runs the eight source clocks at different, mutually unaligned periods. It flips every enable repeatedly while it samples all outputs every nanosecond, so the changes land in every phase of every clock. Each sampled output edge must coincide with a source edge in the same direction.

// File: rtl/clk_oe_pkg.sv
`timescale 1ns/1ps
package clk_oe_pkg;
  typedef enum logic [1:0] {RD_NONE, RD_ENABLE, RD_STRAP} rd_sel_e;

  typedef struct packed {
    logic    loadEnable;
    logic    captureStrap;
    rd_sel_e rdSel;
  } oe_strobe_t;
endpackage

// File: rtl/oe_ctrl.sv
`timescale 1ns/1ps
module oe_ctrl
  import clk_oe_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int ENABLE_ADDR = 5,
  parameter int STRAP_ADDR  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output oe_strobe_t        strobe
);
  localparam logic [ADDR_W-1:0] EnAddr    = ADDR_W'(ENABLE_ADDR);
  localparam logic [ADDR_W-1:0] StrapAddr = ADDR_W'(STRAP_ADDR);

  logic captured;

  // First clock after reset samples the strap pins exactly once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) captured <= 1'b0;
    else       captured <= 1'b1;
  end

  always_comb begin
    strobe.loadEnable   = wrEn && (addr == EnAddr);
    strobe.captureStrap = !captured;
    if (addr == EnAddr)         strobe.rdSel = RD_ENABLE;
    else if (addr == StrapAddr) strobe.rdSel = RD_STRAP;
    else                        strobe.rdSel = RD_NONE;
  end
endmodule

// File: rtl/oe_clk_gate.sv
`timescale 1ns/1ps
module oe_clk_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic srcClk,
  input  logic rstN,
  input  logic enIn,
  output logic clkOut
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   enLatch;

  // Bring the enable into the output's own domain; reset matches power-up "on"
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], enIn};
  end

  // Transparent only during the low phase, so the AND below never clips a pulse
  always_latch begin
    if (!srcClk) enLatch <= syncQ[SYNC_STAGES-1];
  end

  assign clkOut = srcClk & enLatch;
endmodule

// File: rtl/oe_datapath.sv
`timescale 1ns/1ps
module oe_datapath
  import clk_oe_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SEL_BIT     = 5,
  parameter int FS1_BIT     = 3,
  parameter int FS3_BIT     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  oe_strobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              strapSel,
  input  logic              strapFs1,
  input  logic              strapFs3,
  input  logic [DATA_W-1:0] srcClk,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] clkOut,
  output logic [DATA_W-1:0] enableBits,
  output logic [DATA_W-1:0] strapBits
);
  logic [DATA_W-1:0] strapNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  enableBits <= '1;
    else if (strobe.loadEnable) enableBits <= wrData;
  end

  always_comb begin
    strapNext          = '1;
    strapNext[SEL_BIT] = ~strapSel;
    strapNext[FS1_BIT] = ~strapFs1;
    strapNext[FS3_BIT] = ~strapFs3;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    strapBits <= '1;
    else if (strobe.captureStrap) strapBits <= strapNext;
  end

  always_comb begin
    case (strobe.rdSel)
      RD_ENABLE: rdData = enableBits;
      RD_STRAP:  rdData = strapBits;
      default:   rdData = '0;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_gate
    oe_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .srcClk (srcClk[i]),
      .rstN   (rstN),
      .enIn   (enableBits[i]),
      .clkOut (clkOut[i])
    );
  end
endmodule

// File: rtl/clk_oe_bank.sv
`timescale 1ns/1ps
module clk_oe_bank
  import clk_oe_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int ENABLE_ADDR = 5,
  parameter int STRAP_ADDR  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              strapSel,
  input  logic              strapFs1,
  input  logic              strapFs3,
  input  logic [DATA_W-1:0] srcClk,
  output logic [DATA_W-1:0] clkOut
);
  oe_strobe_t        strobe;
  logic [DATA_W-1:0] enableBits;
  logic [DATA_W-1:0] strapBits;

  oe_ctrl #(
    .ADDR_W(ADDR_W), .ENABLE_ADDR(ENABLE_ADDR), .STRAP_ADDR(STRAP_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .strobe(strobe)
  );

  oe_datapath #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .strapSel(strapSel), .strapFs1(strapFs1), .strapFs3(strapFs3),
    .srcClk(srcClk), .rdData(rdData), .clkOut(clkOut),
    .enableBits(enableBits), .strapBits(strapBits)
  );
endmodule

// File: rtl/clk_oe_bank_checker.sv
`timescale 1ns/1ps
module clk_oe_bank_checker #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int ENABLE_ADDR = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] srcClk,
  input logic [DATA_W-1:0] clkOut,
  input logic [DATA_W-1:0] enableBits,
  input logic [DATA_W-1:0] strapBits
);
  localparam logic [ADDR_W-1:0] EnAddr = ADDR_W'(ENABLE_ADDR);

  p_reset_value_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> enableBits == '1);

  p_write_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == EnAddr) |=> enableBits == $past(wrData));

  p_other_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == EnAddr) |=> $stable(enableBits));

  // R7 and R8: once captured, the strap byte never moves
  p_strap_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2)) |-> $stable(strapBits));

  for (genvar i = 0; i < DATA_W; i++) begin : g_out
    p_low_with_src_r6: assert property (@(posedge clk) disable iff (!rstN)
      !srcClk[i] |-> !clkOut[i]);
    p_no_clip_r6: assert property (@(posedge clk) disable iff (!rstN)
      (srcClk[i] && $past(srcClk[i])) |-> clkOut[i] == $past(clkOut[i]));
  end
endmodule

bind clk_oe_bank clk_oe_bank_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENABLE_ADDR(ENABLE_ADDR)
) u_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .srcClk(srcClk), .clkOut(clkOut), .enableBits(enableBits),
  .strapBits(strapBits)
);

// File: tb/clk_oe_bank_bench.sv
`timescale 1ns/1ps
module clk_oe_bank_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       strapSel = 1'b1;
  logic       strapFs1 = 1'b0;
  logic       strapFs3 = 1'b1;
  logic [7:0] srcClk = '0;
  logic [7:0] clkOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Inverted strap byte for sel=1, fs1=0, fs3=1 with reserved ones
  localparam logic [7:0] StrapExp = 8'hDD;

  clk_oe_bank u_clk_oe_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .strapSel(strapSel), .strapFs1(strapFs1),
    .strapFs3(strapFs3), .srcClk(srcClk), .clkOut(clkOut)
  );

  always #5 clk = ~clk;

  // Source clocks: edges at x.5 ns, half periods 16..30 ns
  initial begin
    int cnt[8];
    for (int g = 0; g < 8; g++) cnt[g] = 0;
    #0.5;
    forever begin
      #2;
      for (int g = 0; g < 8; g++) begin
        cnt[g]++;
        if (cnt[g] >= 8 + g) begin
          cnt[g] = 0;
          srcClk[g] = ~srcClk[g];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdData;
  endtask

  // Sample all outputs over a window and compare with the expected enables
  task automatic observe(input logic [7:0] exp, input string tag);
    bit   wrong[8];
    int   highs[8];
    logic [7:0] s, o;
    for (int b = 0; b < 8; b++) begin wrong[b] = 0; highs[b] = 0; end
    for (int t = 0; t < 400; t++) begin
      #1;
      s = srcClk; o = clkOut;
      for (int b = 0; b < 8; b++) begin
        if (exp[b]) begin
          if (o[b] !== s[b]) wrong[b] = 1;
        end else if (o[b] !== 1'b0) wrong[b] = 1;
        if (o[b] === 1'b1) highs[b]++;
      end
    end
    for (int b = 0; b < 8; b++) begin
      if (exp[b])
        check(!wrong[b] && highs[b] > 0, "R5", $sformatf("%s bit%0d runs", tag, b),
              highs[b], 1);
      else
        check(!wrong[b] && highs[b] == 0, "R4", $sformatf("%s bit%0d held low", tag, b),
              highs[b], 0);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    readReg(3'd5, d);
    check(d == 8'hFF, "R1", "enable reset value", d, 8'hFF);
    readReg(3'd4, d);
    check(d == StrapExp, "R7", "strap readback", d, StrapExp);
    observe(8'hFF, "R1 reset");
  endtask

  // R2, R3: pattern lands in the register and on the matching outputs
  task automatic t_pattern(input logic [7:0] p);
    logic [7:0] d;
    writeReg(3'd5, p);
    readReg(3'd5, d);
    check(d == p, "R2", "enable readback", d, p);
    #300;
    observe(p, $sformatf("R3 pattern %02h", p));
  endtask

  task automatic t_strap();
    logic [7:0] d;
    strapSel = 1'b0; strapFs1 = 1'b1; strapFs3 = 1'b0;
    readReg(3'd4, d);
    check(d == StrapExp, "R7", "strap ignores later pins", d, StrapExp);
    writeReg(3'd4, 8'h00);
    readReg(3'd4, d);
    check(d == StrapExp, "R8", "strap write ignored", d, StrapExp);
  endtask

  task automatic t_other_addr();
    logic [7:0] d;
    writeReg(3'd5, 8'h3C);
    writeReg(3'd2, 8'hC3);
    writeReg(3'd7, 8'h00);
    readReg(3'd5, d);
    check(d == 8'h3C, "R9", "enable kept after stray writes", d, 8'h3C);
    readReg(3'd2, d);
    check(d == 8'h00, "R9", "unmapped read", d, 8'h00);
    #300;
    observe(8'h3C, "R9 outputs");
  endtask

  // R6: flip enables while watching every edge
  task automatic t_glitch();
    bit bad[8];
    logic [7:0] ps, po, s, o;
    for (int b = 0; b < 8; b++) bad[b] = 0;
    fork
      begin
        for (int k = 0; k < 10; k++) begin
          writeReg(3'd5, (k % 2 == 0) ? 8'h00 : 8'hFF);
          #(47 + 13 * k);
        end
      end
      begin
        ps = srcClk; po = clkOut;
        for (int t = 0; t < 900; t++) begin
          #1;
          s = srcClk; o = clkOut;
          for (int b = 0; b < 8; b++) begin
            if (o[b] && !s[b]) bad[b] = 1;
            if (o[b] != po[b] && (s[b] == ps[b] || s[b] != o[b])) bad[b] = 1;
          end
          ps = s; po = o;
        end
      end
    join
    for (int b = 0; b < 8; b++)
      check(!bad[b], "R6", $sformatf("bit%0d edges follow source", b), bad[b], 0);
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #50000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #300;
    t_reset();
    t_pattern(8'h00);
    t_pattern(8'hA5);
    t_pattern(8'h5A);
    t_pattern(8'($urandom));
    t_pattern(8'($urandom));
    t_pattern(8'hFF);
    t_strap();
    t_other_addr();
    t_glitch();
    writeReg(3'd5, 8'h81);
    #300;
    observe(8'h81, "R3 final");
    done = 1'b1;
    finish();
  end
endmodule